// File: doc/BRIEF.md
# Ramp Playback Engine with Decimated Phase-Locked Capture

This block plays a sawtooth ramp out of a computed lookup table to a DAC sample port, one step for every second tick of an external tick enable. A repeating eight-slot schedule ties everything to that tick. The even slots update the DAC. The odd slots, in order, start an ADC conversion, wait, wait again, and then collect the conversion result. So exactly one conversion is taken for every four DAC updates. The first conversion of every ramp is issued on the tick right after that ramp's first DAC update.

Collected results go into a ping-pong capture memory that has its own read port. A sticky flag is raised when the lower half has been written and another when the upper half has been written, so a consumer can drain one half while the other fills. If the converter has not reported done when the collect slot arrives, the previous stored value is written again and a sticky late error is raised. The number of samples per ramp is therefore fixed at RAMP_LEN/4.

The schedule is a state machine with eight named states: SL_DAC_A, SL_ADC_GO, SL_DAC_B, SL_GAP_A, SL_DAC_C, SL_GAP_B, SL_DAC_D, SL_COLLECT. There is one transition per tick, each state moves to the next in that list, and SL_COLLECT moves back to SL_DAC_A by masking the incremented index to three bits. When no tick is present, every state holds.

Top module: `ramp_sample_engine`

## Requirements
- R1: After reset the schedule sits in SL_DAC_A, the ramp address is 0, the stored-previous value is 0, and dac_stb, dac_data, ramp_start, adc_start, irq_half, irq_full and err_late are all 0.
- R2: The schedule advances one state per clock in which tick is high and holds otherwise. No DAC, ADC start or collect action happens in a cycle without tick.
- R3: A tick in SL_DAC_A, SL_DAC_B, SL_DAC_C or SL_DAC_D pulses dac_stb for the following cycle and loads dac_data with the table value at the current ramp address. The address then advances and wraps from RAMP_LEN-1 to 0. dac_data holds between updates.
- R4: The table value at address a is a * (2^DAC_W / RAMP_LEN).
- R5: ramp_start pulses together with dac_stb exactly when the update uses address 0.
- R6: A tick in SL_ADC_GO pulses adc_start for the following cycle. This gives one start per four DAC updates, RAMP_LEN/4 per ramp, and the first start of each ramp follows that ramp's first DAC update by one tick.
- R7: A tick in SL_COLLECT with adc_done high writes adc_data into capture entry wptr.
- R8: A tick in SL_COLLECT with adc_done low writes the previously stored value instead and sets err_late, which stays set until cleared.
- R9: wptr starts at 0, advances by one per collect and wraps from CAP_DEPTH-1 to 0.
- R10: irq_half is set by the write to entry CAP_DEPTH/2-1 and irq_full by the write to entry CAP_DEPTH-1. Both are sticky.
- R11: flag_clr bit 0 clears irq_half, bit 1 clears irq_full and bit 2 clears err_late. A set in the same cycle as a clear wins.
- R12: rd_data shows capture entry rd_addr one clock after rd_addr is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Schedule advance enable |
| flag_clr | input | 3 | Write-one-to-clear: [0] half, [1] full, [2] late |
| adc_done | input | 1 | Converter result valid |
| adc_data | input | ADC_W | Converter result |
| rd_addr | input | $clog2(CAP_DEPTH) | Capture read address |
| dac_data | output | DAC_W | DAC sample word |
| dac_stb | output | 1 | DAC update strobe |
| ramp_start | output | 1 | First point of a ramp |
| adc_start | output | 1 | Conversion start pulse |
| rd_data | output | ADC_W | Capture read data |
| irq_half | output | 1 | Lower half written |
| irq_full | output | 1 | Upper half written |
| err_late | output | 1 | Result missing at collect slot |

## Verification
The bench builds the block with RAMP_LEN = 16 and CAP_DEPTH = 8. At those values a ramp lasts 32 ticks and holds four conversions, and the capture memory fills in 64 ticks. A few hundred cycles therefore cover several address wraps, several pointer wraps and repeated half and full events, and continuous, sparse and late-converter tick patterns can all be run.

// File: rtl/rse_pkg.sv
package rse_pkg;

    typedef enum logic [2:0] {
        SL_DAC_A   = 3'd0,
        SL_ADC_GO  = 3'd1,
        SL_DAC_B   = 3'd2,
        SL_GAP_A   = 3'd3,
        SL_DAC_C   = 3'd4,
        SL_GAP_B   = 3'd5,
        SL_DAC_D   = 3'd6,
        SL_COLLECT = 3'd7
    } slot_e;

    typedef struct packed {
        logic dac;
        logic go;
        logic collect;
    } act_t;

    localparam int SLOT_COUNT = 8;

endpackage

// File: rtl/rse_sched.sv
module rse_sched
    import rse_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    output act_t  act
);
    localparam logic [2:0] SLOT_MASK = 3'(SLOT_COUNT - 1);

    slot_e slot_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slot_q <= SL_DAC_A;
        end else if (tick) begin
            slot_q <= slot_e'((slot_q + 3'd1) & SLOT_MASK);
        end
    end

    always_comb begin
        act = '0;
        unique case (slot_q)
            SL_DAC_A, SL_DAC_B, SL_DAC_C, SL_DAC_D: act.dac     = tick;
            SL_ADC_GO:                              act.go      = tick;
            SL_COLLECT:                             act.collect = tick;
            SL_GAP_A, SL_GAP_B:                     act         = '0;
            default:                                act         = '0;
        endcase
    end

    AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(slot_q)); // R2

endmodule

// File: rtl/rse_wave.sv
module rse_wave #(
    parameter int RAMP_LEN = 2048,
    parameter int DAC_W    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [DAC_W-1:0] dac_data,
    output logic             dac_stb,
    output logic             ramp_start
);
    localparam int AW       = $clog2(RAMP_LEN);
    localparam int STEP_SH  = DAC_W - AW;
    localparam logic [AW-1:0] LAST = AW'(RAMP_LEN - 1);

    logic [AW-1:0]    addr_q;
    logic [DAC_W-1:0] level;

    always_comb level = DAC_W'(addr_q) << STEP_SH;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q     <= '0;
            dac_data   <= '0;
            dac_stb    <= 1'b0;
            ramp_start <= 1'b0;
        end else begin
            dac_stb    <= adv;
            ramp_start <= adv && (addr_q == '0);
            if (adv) begin
                dac_data <= level;
                addr_q   <= (addr_q == LAST) ? '0 : addr_q + 1'b1;
            end
        end
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(addr_q)); // R3

endmodule

// File: rtl/rse_capture.sv
module rse_capture #(
    parameter int DEPTH = 64,
    parameter int ADC_W = 12,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             collect,
    input  logic             adc_done,
    input  logic [ADC_W-1:0] adc_data,
    input  logic [2:0]       flag_clr,
    input  logic [AW-1:0]    rd_addr,
    output logic [ADC_W-1:0] rd_data,
    output logic             irq_half,
    output logic             irq_full,
    output logic             err_late
);
    localparam logic [AW-1:0] HALF_TOP = AW'(DEPTH / 2 - 1);
    localparam logic [AW-1:0] FULL_TOP = AW'(DEPTH - 1);

    logic [ADC_W-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr;
    logic [ADC_W-1:0] last_q;
    logic [ADC_W-1:0] wval;
    logic             set_half, set_full, set_late;

    always_comb begin
        wval     = adc_done ? adc_data : last_q;
        set_half = collect && (wptr == HALF_TOP);
        set_full = collect && (wptr == FULL_TOP);
        set_late = collect && !adc_done;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr     <= '0;
            last_q   <= '0;
            irq_half <= 1'b0;
            irq_full <= 1'b0;
            err_late <= 1'b0;
        end else begin
            if (collect) begin
                wptr   <= (wptr == FULL_TOP) ? '0 : wptr + 1'b1;
                last_q <= wval;
            end
            irq_half <= (irq_half && !flag_clr[0]) || set_half;
            irq_full <= (irq_full && !flag_clr[1]) || set_full;
            err_late <= (err_late && !flag_clr[2]) || set_late;
        end
    end

    always_ff @(posedge clk) begin
        if (collect) mem[wptr] <= wval;
        rd_data <= mem[rd_addr];
    end

    AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !collect |=> $stable(wptr)); // R9
    AST_FULL_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_full) |-> (wptr == '0)); // R10
    AST_LATE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err_late && !flag_clr[2]) |=> err_late); // R8
    AST_HALF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_half && !flag_clr[0]) |=> irq_half); // R11

endmodule

// File: rtl/ramp_sample_engine.sv
module ramp_sample_engine
    import rse_pkg::*;
#(
    parameter int RAMP_LEN  = 2048,
    parameter int DAC_W     = 12,
    parameter int ADC_W     = 12,
    parameter int CAP_DEPTH = 64,
    localparam int CAW      = $clog2(CAP_DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [2:0]       flag_clr,
    input  logic             adc_done,
    input  logic [ADC_W-1:0] adc_data,
    input  logic [CAW-1:0]   rd_addr,
    output logic [DAC_W-1:0] dac_data,
    output logic             dac_stb,
    output logic             ramp_start,
    output logic             adc_start,
    output logic [ADC_W-1:0] rd_data,
    output logic             irq_half,
    output logic             irq_full,
    output logic             err_late
);
    act_t act;

    rse_sched u_sched (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .act  (act)
    );

    rse_wave #(.RAMP_LEN(RAMP_LEN), .DAC_W(DAC_W)) u_wave (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (act.dac),
        .dac_data  (dac_data),
        .dac_stb   (dac_stb),
        .ramp_start(ramp_start)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) adc_start <= 1'b0;
        else        adc_start <= act.go;
    end

    rse_capture #(.DEPTH(CAP_DEPTH), .ADC_W(ADC_W)) u_cap (
        .clk     (clk),
        .rst_n   (rst_n),
        .collect (act.collect),
        .adc_done(adc_done),
        .adc_data(adc_data),
        .flag_clr(flag_clr),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .irq_half(irq_half),
        .irq_full(irq_full),
        .err_late(err_late)
    );

    AST_DAC_ADC_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(dac_stb && adc_start)); // R6
    AST_RAMP_WITH_STB: assert property (@(posedge clk) disable iff (!rst_n)
        ramp_start |-> dac_stb); // R5

endmodule

// File: tb/ramp_sample_engine_tb_top.sv
module ramp_sample_engine_tb_top;
    localparam int RAMP_LEN  = 16;
    localparam int DAC_W     = 12;
    localparam int ADC_W     = 12;
    localparam int CAP_DEPTH = 8;
    localparam int CAW       = $clog2(CAP_DEPTH);

    logic             clk = 1'b0;
    logic             rst_n;
    logic             tick;
    logic [2:0]       flag_clr;
    logic             adc_done;
    logic [ADC_W-1:0] adc_data;
    logic [CAW-1:0]   rd_addr;
    logic [DAC_W-1:0] dac_data;
    logic             dac_stb, ramp_start, adc_start;
    logic [ADC_W-1:0] rd_data;
    logic             irq_half, irq_full, err_late;

    always #2.5 clk = ~clk;

    ramp_sample_engine #(
        .RAMP_LEN(RAMP_LEN), .DAC_W(DAC_W), .ADC_W(ADC_W), .CAP_DEPTH(CAP_DEPTH)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .flag_clr(flag_clr),
        .adc_done(adc_done), .adc_data(adc_data), .rd_addr(rd_addr),
        .dac_data(dac_data), .dac_stb(dac_stb), .ramp_start(ramp_start),
        .adc_start(adc_start), .rd_data(rd_data), .irq_half(irq_half),
        .irq_full(irq_full), .err_late(err_late)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit run_cmp = 0;
    bit finished = 0;

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // fixed-latency converter responder
    int rsp_lat = 2;
    int rsp_cnt = 0;
    int rsp_val = 100;
    always @(negedge clk) begin
        if (!rst_n) begin
            adc_done = 1'b0;
            adc_data = '0;
            rsp_cnt  = 0;
        end else if (adc_start) begin
            adc_done = 1'b0;
            rsp_cnt  = rsp_lat;
            rsp_val  = (rsp_val * 5 + 37) % 4096;
        end else if (rsp_cnt > 0) begin
            rsp_cnt--;
            if (rsp_cnt == 0) begin
                adc_done = 1'b1;
                adc_data = ADC_W'(rsp_val);
            end
        end
    end

    // behavioural reference model
    int m_ticks, m_dac, m_wp, m_last;
    bit m_stb, m_ramp, m_go, m_half, m_full, m_late;
    int cmem [CAP_DEPTH];

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ticks = 0; m_dac = 0; m_wp = 0; m_last = 0;
            m_stb = 0; m_ramp = 0; m_go = 0;
            m_half = 0; m_full = 0; m_late = 0;
        end else begin
            int slot, val;
            bit sh, sf, sl;
            m_stb = 0; m_ramp = 0; m_go = 0;
            sh = 0; sf = 0; sl = 0;
            if (tick) begin
                slot = m_ticks % 8;
                if (slot % 2 == 0) begin
                    int p;
                    p = (m_ticks / 2) % RAMP_LEN;
                    m_stb  = 1;
                    m_ramp = (p == 0);
                    m_dac  = (p * ((1 << DAC_W) / RAMP_LEN)) % (1 << DAC_W);
                end
                if (slot == 1) m_go = 1;
                if (slot == 7) begin
                    val = adc_done ? int'(adc_data) : m_last;
                    sl  = !adc_done;
                    cmem[m_wp] = val;
                    m_last = val;
                    sh = (m_wp == CAP_DEPTH / 2 - 1);
                    sf = (m_wp == CAP_DEPTH - 1);
                    m_wp = (m_wp + 1) % CAP_DEPTH;
                end
                m_ticks++;
            end
            if (flag_clr[0]) m_half = 0;
            if (flag_clr[1]) m_full = 0;
            if (flag_clr[2]) m_late = 0;
            if (sh) m_half = 1;
            if (sf) m_full = 1;
            if (sl) m_late = 1;
        end
    end

    // per-cycle comparison
    always @(negedge clk) begin
        if (rst_n && run_cmp) begin
            chk("R3/R4 dac_stb",   int'(dac_stb),    int'(m_stb));
            chk("R3/R4 dac_data",  int'(dac_data),   m_dac);
            chk("R5 ramp_start",   int'(ramp_start), int'(m_ramp));
            chk("R2/R6 adc_start", int'(adc_start),  int'(m_go));
            chk("R10/R11 irq_half", int'(irq_half),  int'(m_half));
            chk("R10/R11 irq_full", int'(irq_full),  int'(m_full));
            chk("R8/R11 err_late", int'(err_late),   int'(m_late));
        end
    end

    task automatic readback();
        tick = 1'b0;
        flag_clr = '0;
        for (int i = 0; i < CAP_DEPTH; i++) begin
            @(negedge clk);
            rd_addr = CAW'(i);
            @(negedge clk);
            chk("R7/R9/R12 capture entry", int'(rd_data), cmem[i]);
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        logic [7:0] lf;
        rst_n = 1'b0; tick = 1'b0; flag_clr = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 dac_stb",    int'(dac_stb),    0);
        chk("R1 dac_data",   int'(dac_data),   0);
        chk("R1 ramp_start", int'(ramp_start), 0);
        chk("R1 adc_start",  int'(adc_start),  0);
        chk("R1 irq_half",   int'(irq_half),   0);
        chk("R1 irq_full",   int'(irq_full),   0);
        chk("R1 err_late",   int'(err_late),   0);
        rst_n = 1'b1;
        run_cmp = 1;

        // continuous ticks, prompt converter, mid-run clear of half/full
        for (int i = 0; i < 160; i++) begin
            @(negedge clk);
            tick = 1'b1;
            flag_clr = (i == 100) ? 3'b011 : 3'b000;
        end
        readback();

        // sparse ticks (R2)
        lf = 8'h5A;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            tick = lf[0];
            flag_clr = (i == 150) ? 3'b111 : 3'b000;
            lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        end
        readback();

        // late converter (R8), clear while setting, then recovery
        rsp_lat = 40;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            tick = 1'b1;
            flag_clr = (i == 30) ? 3'b100 : 3'b000;
        end
        rsp_lat = 2;
        for (int i = 0; i < 96; i++) begin
            @(negedge clk);
            tick = 1'b1;
            flag_clr = (i == 20) ? 3'b111 : 3'b000;
        end
        readback();

        @(negedge clk);
        finished = 1;
        summary();
    end

endmodule